// File: doc/BRIEF.md
# Dual-Clock FIFO Core with Selectable Read Timing

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words of 18 bits enter on the write clock when the write enable is high and leave on the read clock. The storage depth is a power-of-two parameter. A strap input is sampled while master reset is held, and it picks one of two read timings.

In standard timing, every word needs a read request, including the first one. The requested word appears on the data output one read edge after the request. In fall-through timing, the oldest word is moved to the output register on its own. It stays there until a read request consumes it. Because the output register holds a word, this mode gives one more word of capacity.

Two resets are provided. Master reset clears everything and latches the timing strap. Partial reset empties the buffer and keeps the timing that was latched. A retransmit input rewinds the read side to the first storage location so that the data can be read again. The write side exports a word count. Flag logic outside the block can use it.

Top module: `dcf_fifo_core`

## Requirements
- R1: The timing mode is the level of `modeStrap` sampled on read-clock edges while `mrstN` is low: 0 selects standard timing, 1 selects fall-through timing. Changes of `modeStrap` after master reset have no effect. In standard timing `rdData` keeps its value until a read is requested. In fall-through timing the head word is presented with `rdEn` low.
- R2: After one word is written into an empty buffer, `rdEmpty` goes low on the third read-clock rising edge after the write edge, in both modes.
- R3: In standard timing with no reads, `wrFull` is 0 after DEPTH-1 accepted writes and is 1 right after the DEPTH-th write edge. After settling, `wrCount` equals DEPTH.
- R4: In fall-through timing with no reads, DEPTH+1 writes are accepted before `wrFull` holds at 1. After settling, `wrCount` equals DEPTH+1.
- R5: A write attempted while `wrFull` is 1 is dropped. The write address does not advance, the count does not grow, and no stored word is disturbed.
- R6: A read request while `rdEmpty` is 1 is ignored. In standard timing `rdData` holds its previous value.
- R7: Words leave in the order they were accepted, in both modes and under concurrent traffic. In fall-through timing a presented word stays on `rdData` until it is consumed by `rdEn`.
- R8: After master reset, `rdEmpty` is 1, `wrFull` is 0, `wrCount` is 0 and `rdData` is all zeros.
- R9: Partial reset (`prstN` low) has the same effect on the buffer as R8, and the latched timing mode is kept.
- R10: `rtEn` high on a read-clock edge rewinds reading to the first stored word. `rdEmpty` is 1 after that edge. The write side is left as it was, so the settled count returns to the number of words written since reset. Valid while at most DEPTH words have been written since the last reset.
- R11: After settling, `wrCount` equals the words accepted minus the words read. In fall-through timing this includes a word waiting in the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, clears all state and latches the mode |
| prstN | input | 1 | Partial reset, active low, clears the buffer and keeps the mode |
| modeStrap | input | 1 | Timing select sampled during master reset (0 standard, 1 fall-through) |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data |
| wrFull | output | 1 | No room for a write (full, or input not ready) |
| wrCount | output | log2(DEPTH)+1 | Words held, as seen from the write side |
| rdEn | input | 1 | Read request |
| rtEn | input | 1 | Retransmit: rewind reading to the first location |
| rdData | output | DATA_W | Read data register |
| rdEmpty | output | 1 | Empty (standard) or output not ready (fall-through) |

## Verification
Each result has its own due time. `wrFull` changes on the same write edge that accepts the filling word. `rdEmpty` releases on the third read edge after a write. A standard-mode word is due one read edge after its request. The count is valid only after the pointer crossing, about three edges. The bench drives read inputs at the falling read edge and samples the reference model 2 ns before each rising read edge, so every data comparison falls one request after the edge that produced it. Count and flag checks that depend on the crossing are made only after a fixed settling window of eight write clocks. The latency checks count the rising read edges one by one.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic memWrite;  // write-clock domain: store wrData at wrAddr
    logic memFetch;  // read-clock domain: load the output register from rdAddr
  } dcf_strobe_t;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_datapath.sv
`timescale 1ns/1ps
module dcf_datapath #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rstN,
  input  dcf_pkg::dcf_strobe_t stb,
  input  logic [AW-1:0]        wrAddr,
  input  logic [AW-1:0]        rdAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.memWrite) store[wrAddr] <= wrData;
  end

  // Output register: cleared by either reset, loaded on a fetch strobe.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)             outReg <= '0;
    else if (stb.memFetch) outReg <= store[rdAddr];
  end

  assign rdData = outReg;
endmodule

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
module dcf_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 mrstN,
  input  logic                 rstN,
  input  logic                 modeStrap,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 rtEn,
  output dcf_pkg::dcf_strobe_t stb,
  output logic [AW-1:0]        wrAddr,
  output logic [AW-1:0]        rdAddr,
  output logic                 wrFull,
  output logic [PW-1:0]        wrCount,
  output logic                 rdEmpty,
  output logic                 fwftMode
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- mode latch (read domain) ----------------
  always_ff @(posedge rdClk) begin
    if (!mrstN) fwftMode <= modeStrap;
  end

  // ---------------- write domain ----------------
  logic [PW-1:0] wPtr, wPtrNext, wGray;
  logic [PW-1:0] rGraySync, cGraySync, rBinW, cBinW;
  logic [PW-1:0] countQ;
  logic          fullQ, wAccept;

  // Read-side pointers are brought over as Gray code.
  logic [PW-1:0] rGray, cGray;
  dcf_sync #(.W(PW)) u_syncR (.clk(wrClk), .rstN(rstN), .d(rGray), .q(rGraySync));
  dcf_sync #(.W(PW)) u_syncC (.clk(wrClk), .rstN(rstN), .d(cGray), .q(cGraySync));

  assign rBinW    = gray2bin(rGraySync);
  assign cBinW    = gray2bin(cGraySync);
  assign wAccept  = wrEn && !fullQ;
  assign wPtrNext = wPtr + PW'(wAccept);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wPtr   <= '0;
      wGray  <= '0;
      fullQ  <= 1'b0;
      countQ <= '0;
    end else begin
      wPtr   <= wPtrNext;
      wGray  <= bin2gray(wPtrNext);
      fullQ  <= ((wPtrNext - rBinW) == FULL_LVL);
      countQ <= wPtrNext - cBinW;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] wGraySync, wBinR;
  logic [PW-1:0] rPtr, rPtrNext, cPtr;
  logic          emptyQ, outValid, memAvail, fetch, consume;

  dcf_sync #(.W(PW)) u_syncW (.clk(rdClk), .rstN(rstN), .d(wGray), .q(wGraySync));

  assign wBinR    = gray2bin(wGraySync);
  assign memAvail = (rPtr != wBinR);

  always_comb begin
    if (fwftMode) begin
      fetch   = !rtEn && memAvail && (!outValid || rdEn);
      consume = !rtEn && rdEn && outValid;
    end else begin
      fetch   = !rtEn && rdEn && !emptyQ;
      consume = fetch;
    end
  end

  assign rPtrNext = rPtr + PW'(fetch);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rPtr     <= '0;
      cPtr     <= '0;
      rGray    <= '0;
      cGray    <= '0;
      emptyQ   <= 1'b1;
      outValid <= 1'b0;
    end else if (rtEn) begin
      rPtr     <= '0;
      cPtr     <= '0;
      rGray    <= '0;
      cGray    <= '0;
      emptyQ   <= 1'b1;
      outValid <= 1'b0;
    end else begin
      rPtr     <= rPtrNext;
      cPtr     <= cPtr + PW'(consume);
      rGray    <= bin2gray(rPtrNext);
      cGray    <= bin2gray(cPtr + PW'(consume));
      emptyQ   <= (rPtrNext == wBinR);
      outValid <= fetch || (outValid && !rdEn);
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    stb.memWrite = wAccept;
    stb.memFetch = fetch;
  end

  assign wrAddr  = wPtr[AW-1:0];
  assign rdAddr  = rPtr[AW-1:0];
  assign wrFull  = fullQ;
  assign wrCount = countQ;
  assign rdEmpty = fwftMode ? !outValid : emptyQ;
endmodule

// File: rtl/dcf_fifo_core.sv
`timescale 1ns/1ps
module dcf_fifo_core #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic                      wrClk,
  input  logic                      rdClk,
  input  logic                      mrstN,
  input  logic                      prstN,
  input  logic                      modeStrap,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  output logic                      wrFull,
  output logic [$clog2(DEPTH):0]    wrCount,
  input  logic                      rdEn,
  input  logic                      rtEn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdEmpty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic                 rstN;
  logic                 fwftMode;
  logic [AW-1:0]        wrAddr, rdAddr;
  dcf_pkg::dcf_strobe_t stb;

  assign rstN = mrstN & prstN;

  dcf_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .rstN(rstN),
    .modeStrap(modeStrap), .wrEn(wrEn), .rdEn(rdEn), .rtEn(rtEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .wrFull(wrFull),
    .wrCount(wrCount), .rdEmpty(rdEmpty), .fwftMode(fwftMode)
  );

  dcf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_datapath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dcf_fifo_checker.sv
`timescale 1ns/1ps
module dcf_fifo_checker #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int PW     = AW + 1
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              fwftMode,
  input logic              wrEn,
  input logic              wrFull,
  input logic [AW-1:0]     wrAddr,
  input logic [PW-1:0]     wrCount,
  input logic              rdEn,
  input logic              rtEn,
  input logic              rdEmpty,
  input logic [DATA_W-1:0] rdData
);
  // R5: a write offered while full must not move the write address.
  a_r5_full_write_ignored: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrFull && wrEn) |=> $stable(wrAddr));

  // R6: standard timing, a read request on an empty buffer leaves the output alone.
  a_r6_empty_read_ignored: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && rdEmpty) |=> $stable(rdData));

  // R7: fall-through timing, a presented word is held until consumed.
  a_r7_fwft_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && !rdEmpty && !rdEn && !rtEn) |=> (!rdEmpty && $stable(rdData)));

  // R10: the edge after a retransmit shows no readable word.
  a_r10_rt_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    rtEn |=> rdEmpty);

  // R3, R4: the count never exceeds the capacity of the selected timing.
  a_r4_count_bound: assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= (fwftMode ? PW'(DEPTH + 1) : PW'(DEPTH)));
endmodule

bind dcf_fifo_core dcf_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_dcfChecker (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
  .wrEn(wrEn), .wrFull(wrFull), .wrAddr(wrAddr), .wrCount(wrCount),
  .rdEn(rdEn), .rtEn(rtEn), .rdEmpty(rdEmpty), .rdData(rdData)
);

// File: tb/test_dcf_fifo_core.sv
`timescale 1ns/1ps
module test_dcf_fifo_core;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 16;
  localparam int PW     = $clog2(DEPTH) + 1;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, modeStrap = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, rtEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrFull, rdEmpty;
  logic [PW-1:0]     wrCount;
  logic [DATA_W-1:0] rdData;

  always #10 wrClk = ~wrClk;                 // 50 MHz
  initial begin #7; forever #10 rdClk = ~rdClk; end  // 50 MHz, offset phase

  dcf_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dcf_fifo_core (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .modeStrap(modeStrap), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .wrCount(wrCount), .rdEn(rdEn), .rtEn(rtEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  // ---------------- reference model state ----------------
  logic [DATA_W-1:0] hist [0:255];
  int  wIdx = 0, rIdx = 0;
  int  checks = 0, errors = 0;
  bit  fwftExp = 0, pending = 0;
  logic [DATA_W-1:0] expWord = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read-side model: samples 2 ns before every rising read edge.
  initial begin
    forever begin
      @(negedge rdClk); #8;
      if (!(mrstN && prstN)) begin
        rIdx = 0; pending = 0;
      end else begin
        if (pending) begin
          check(rdData == expWord, "R7 standard read data", rdData, expWord);
          pending = 0;
        end
        if (fwftExp && !rdEmpty)
          check(rdData == hist[rIdx], "R7 fall-through head word", rdData, hist[rIdx]);
        if (rtEn) rIdx = 0;
        else if (rdEn && !rdEmpty) begin
          if (!fwftExp) begin expWord = hist[rIdx]; pending = 1; end
          rIdx++;
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic masterReset(input bit mode);
    @(negedge wrClk);
    mrstN = 0; modeStrap = mode; wrEn = 0; rdEn = 0; rtEn = 0;
    repeat (4) @(negedge rdClk);
    fwftExp = mode; wIdx = 0;
    mrstN = 1; modeStrap = ~mode;   // later strap changes must be ignored (R1)
    repeat (3) @(negedge wrClk);
  endtask

  task automatic partialReset();
    @(negedge rdClk);
    prstN = 0;
    repeat (2) @(negedge rdClk);
    wIdx = 0; prstN = 1;
    repeat (3) @(negedge wrClk);
  endtask

  task automatic attemptWrite(input logic [DATA_W-1:0] d, output bit acc);
    @(negedge wrClk);
    wrEn = 1; wrData = d; acc = !wrFull;
    @(posedge wrClk);
    if (acc) begin hist[wIdx] = d; wIdx++; end
    #1 wrEn = 0;
  endtask

  task automatic readCycles(input int n);
    for (int i = 0; i < n; i++) begin @(negedge rdClk); rdEn = 1; end
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic pulseRetransmit();
    @(negedge rdClk); rtEn = 1;
    @(negedge rdClk); rtEn = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
  endtask

  // Counts rising read edges after a write until rdEmpty falls.
  task automatic firstLatency(output int n);
    n = 0;
    do begin @(posedge rdClk); #3; n++; end while (rdEmpty && n < 10);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    check(1'b0, "R7 watchdog expired", 0, 1);
    finishRun();
  end

  // ---------------- main sequence ----------------
  initial begin
    bit acc;
    int lat;

    // ===== standard timing =====
    masterReset(1'b0);
    check(rdEmpty == 1, "R8 empty after master reset", rdEmpty, 1);
    check(wrFull == 0, "R8 not full after master reset", wrFull, 0);
    check(wrCount == 0, "R8 count zero after master reset", wrCount, 0);
    check(rdData == 0, "R8 output cleared by master reset", rdData, 0);

    attemptWrite(18'h1A001, acc);
    firstLatency(lat);
    check(lat == 3, "R2 standard empty release edge", lat, 3);
    settle();
    check(rdData == 0, "R1 standard timing waits for a request", rdData, 0);
    check(wrCount == 1, "R11 count one word", wrCount, 1);

    readCycles(1); settle();
    check(rdData == hist[0], "R7 requested word on output", rdData, hist[0]);
    check(rdEmpty == 1, "R6 empty after last read", rdEmpty, 1);
    readCycles(3); settle();
    check(rdData == hist[0], "R6 read on empty ignored", rdData, hist[0]);
    check(wrCount == 0, "R11 count after draining", wrCount, 0);

    for (int i = 0; i < DEPTH; i++) begin
      attemptWrite(18'h20000 + 18'(i * 7), acc);
      if (i == DEPTH - 2) check(wrFull == 0, "R3 not full one short", wrFull, 0);
    end
    check(wrFull == 1, "R3 full after DEPTH writes", wrFull, 1);
    settle();
    check(wrCount == PW'(DEPTH), "R3 count equals DEPTH", wrCount, DEPTH);
    attemptWrite(18'h3FFFF, acc);
    check(acc == 0, "R5 write while full refused", acc, 0);
    attemptWrite(18'h3FFFE, acc);
    settle();
    check(wrCount == PW'(DEPTH), "R5 count unchanged by refused writes", wrCount, DEPTH);

    readCycles(DEPTH + 2); settle();
    check(rdEmpty == 1, "R7 empty after drain", rdEmpty, 1);
    check(rIdx == wIdx, "R7 every word delivered once", rIdx, wIdx);
    check(wrCount == 0 && wrFull == 0, "R11 count zero after drain", wrCount, 0);

    // retransmit, standard timing
    masterReset(1'b0);
    for (int i = 0; i < 5; i++) attemptWrite(18'h05500 + 18'(i), acc);
    settle(); readCycles(3); settle();
    check(wrCount == 2, "R11 count after three reads", wrCount, 2);
    pulseRetransmit();
    check(rdEmpty == 1, "R10 standard empty after retransmit", rdEmpty, 1);
    settle();
    check(wrCount == 5, "R10 count back to words written", wrCount, 5);
    check(wrFull == 0, "R10 write side undisturbed", wrFull, 0);
    readCycles(5); settle();
    check(rIdx == 5, "R10 five words re-read from the start", rIdx, 5);
    check(rdEmpty == 1, "R10 empty after re-read", rdEmpty, 1);

    // ===== fall-through timing =====
    masterReset(1'b1);
    check(rdEmpty == 1, "R8 not ready after master reset", rdEmpty, 1);
    check(rdData == 0, "R8 output cleared in fall-through", rdData, 0);
    attemptWrite(18'h2B0B0, acc);
    firstLatency(lat);
    check(lat == 3, "R2 fall-through ready edge", lat, 3);
    check(rdData == hist[0], "R1 head word presented without request", rdData, hist[0]);
    settle();
    check(wrCount == 1, "R11 count includes output register word", wrCount, 1);

    for (int i = 0; i < DEPTH; i++) attemptWrite(18'h30000 + 18'(i * 3), acc);
    check(wrFull == 1, "R4 full after DEPTH+1 writes", wrFull, 1);
    settle();
    check(wIdx == DEPTH + 1, "R4 DEPTH+1 words accepted", wIdx, DEPTH + 1);
    check(wrCount == PW'(DEPTH + 1), "R4 count equals DEPTH+1", wrCount, DEPTH + 1);
    attemptWrite(18'h0DEAD, acc);
    check(acc == 0, "R5 fall-through write while full refused", acc, 0);

    readCycles(DEPTH + 3); settle();
    check(rdEmpty == 1, "R7 not ready after drain", rdEmpty, 1);
    check(rIdx == wIdx, "R7 fall-through every word delivered", rIdx, wIdx);
    check(wrCount == 0, "R11 fall-through count zero", wrCount, 0);

    // partial reset keeps the mode
    for (int i = 0; i < 3; i++) attemptWrite(18'h11100 + 18'(i), acc);
    settle();
    partialReset();
    check(rdEmpty == 1, "R9 not ready after partial reset", rdEmpty, 1);
    check(wrCount == 0, "R9 count zero after partial reset", wrCount, 0);
    check(rdData == 0, "R9 output cleared by partial reset", rdData, 0);
    check(wrFull == 0, "R9 not full after partial reset", wrFull, 0);
    attemptWrite(18'h0C0C0, acc);
    firstLatency(lat);
    check(lat == 3, "R9 fall-through timing kept", lat, 3);
    check(rdData == hist[0], "R9 head word presented", rdData, hist[0]);

    // retransmit, fall-through timing
    for (int i = 0; i < 4; i++) attemptWrite(18'h0E000 + 18'(i), acc);
    settle(); readCycles(2); settle();
    check(wrCount == 3, "R11 fall-through count after consuming two", wrCount, 3);
    pulseRetransmit();
    check(rdEmpty == 1, "R10 fall-through not ready after retransmit", rdEmpty, 1);
    settle();
    check(rdEmpty == 0 && rdData == hist[0], "R10 first word presented again", rdData, hist[0]);
    check(wrCount == 5, "R10 fall-through count back to written", wrCount, 5);
    readCycles(5); settle();
    check(rIdx == 5, "R10 fall-through re-read count", rIdx, 5);

    // concurrent traffic in fall-through timing
    fork
      begin
        bit ok;
        for (int i = 0; i < 30; i++) begin
          do attemptWrite(18'h15000 + 18'(i * 11), ok); while (!ok);
        end
      end
      begin
        for (int i = 0; i < 90; i++) begin @(negedge rdClk); rdEn = (i % 3 != 0); end
        @(negedge rdClk); rdEn = 0;
      end
    join
    settle(); readCycles(DEPTH + 2); settle();
    check(wIdx == 35, "R7 traffic words accepted", wIdx, 35);
    check(rIdx == wIdx, "R7 traffic words delivered in order", rIdx, wIdx);
    check(wrCount == 0 && rdEmpty == 1, "R11 traffic drained", wrCount, 0);

    finishRun();
  end
endmodule